// File: doc/BRIEF.md
# Hardwired Timing-Signal Controller

This block is the hardwired sequencer of a small 16-bit accumulator machine. It holds the instruction register and splits each instruction word into three fields. Bit 15 is the indirect flag, bits 14..12 are the opcode and bits 11..0 are the address. A sequence counter is decoded into one-hot timing lines. The opcode is decoded into one-hot instruction lines. Gate terms built from the timing lines, the instruction lines, the current cycle type and the flags drive every register transfer. Those transfers load the memory address register, the memory buffer register, the program counter, the instruction register and the accumulator.

The controller steps through four fixed-slot cycle types: fetch, indirect, execute and interrupt. Two opcodes do real work. Opcode 1 adds a memory word to the accumulator. Opcode 6 increments a memory word, writes it back and skips the next instruction when the result is zero. Every other opcode is a one-slot no-operation. The block talks to a synchronous memory through a read strobe and a write strobe. It polls an interrupt request only at instruction boundaries, and only while its enable flag is set.

Top module: `seqctl_top`

## Requirements
- R1: While reset is held and until the first functional clock edge, the program counter and accumulator read 0, timing line T0 alone is active (`tsig_o` = 0x0001), the interrupt enable reads 0, and a fetch read of address 0 is being requested.
- R2: The timing lines are a one-hot decode of the sequence counter. Within a cycle type the active line moves up by one each clock. When a cycle type ends, the counter clears synchronously, so T0 is the next active line.
- R3: After fetch, `dsig_o` has only bit n set, where n is the value of instruction bits 14..12. Bit 15 of `ir_o` holds the indirect flag.
- R4: Fetch takes three slots. In the first, a read is issued at the program counter. In the second, the buffer captures the word and the program counter increments. In the third, the word is copied into the instruction register.
- R5: When the indirect flag is 1, a three-slot indirect cycle follows the fetch. It reads the word at the address field and replaces the address field with that word's bits 11..0. Execution then uses this effective address.
- R6: Opcode 1 runs in three slots. It reads the word at the effective address and adds it to the accumulator modulo 2^16.
- R7: Opcode 6 runs in four slots. It reads the word at the effective address and increments it in the buffer. In the fourth slot it writes the word back, and it also increments the program counter when the new value is 0.
- R8: Every opcode other than 1 and 6 finishes in one execute slot. It leaves the accumulator and memory unchanged and returns to fetch.
- R9: The `ien_set` pulse sets the interrupt enable. When an instruction ends with `irq` high and the enable set, the enable clears and a three-slot interrupt cycle runs. That cycle saves the program counter into the buffer, loads the save address 0x0F0 and the routine address 0x080, and writes the saved counter to address 0x0F0. Without the enable, a fetch follows.
- R10: Memory reads have one cycle of latency. A read is requested only in slots that load the address register from the program counter or from the address field, and `mem_addr` then carries that new address. Writes take place only in the fourth slot of opcode 6 and the third interrupt slot, at the address register, with the buffer as data. A read and a write are never requested together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq | input | 1 | Interrupt request level |
| ien_set | input | 1 | One-cycle pulse that sets the interrupt enable |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| mem_addr | output | 12 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (buffer register) |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| ir_o | output | 16 | Indirect flag, opcode and address field |
| tsig_o | output | 16 | One-hot timing lines T0..T15 |
| dsig_o | output | 8 | One-hot instruction lines D0..D7 |
| ien_o | output | 1 | Interrupt enable flag |

## Verification
Each result has a fixed due cycle counted from the start of its instruction. The decoded instruction lines and the loaded instruction register are due after three edges. A rewritten address field is due three edges later. The accumulator result is due on the last execute edge, the sixth for a direct add. A write-back and any skip are due on the fourth execute edge. In the interrupt cycle, the write strobe is visible after two edges and the saved word lands on the third. The bench counts exactly that many edges from each instruction's start and samples one time unit after the edge. It derives each instruction's length from its opcode and indirect flag, so every comparison falls in the cycle where the value first becomes due.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;
  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_INDIR = 2'd1,
    PH_EXEC  = 2'd2,
    PH_INTR  = 2'd3
  } phase_e;

  localparam int unsigned OP_ADD = 1;
  localparam int unsigned OP_ISZ = 6;
endpackage

// File: rtl/seqctl_seqcnt.sv
module seqctl_seqcnt #(
  parameter  int unsigned SCW = 4,
  localparam int unsigned NT  = 1 << SCW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [NT-1:0] tsig
);
  logic [SCW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tline
    assign tsig[i] = (cnt_q == SCW'(i));
  end
endmodule

// File: rtl/seqctl_opdec.sv
module seqctl_opdec #(
  parameter  int unsigned OPW = 3,
  localparam int unsigned ND  = 1 << OPW
) (
  input  logic [OPW-1:0] op,
  output logic [ND-1:0]  dsig
);
  for (genvar i = 0; i < ND; i++) begin : g_dline
    assign dsig[i] = (op == OPW'(i));
  end
endmodule

// File: rtl/seqctl_top.sv
module seqctl_top
  import seqctl_pkg::*;
#(
  parameter  int unsigned AW        = 12,
  parameter  int unsigned OPW       = 3,
  parameter  int unsigned SCW       = 4,
  parameter  logic [11:0] SAVE_ADDR = 12'h0F0,
  parameter  logic [11:0] ISR_ADDR  = 12'h080,
  localparam int unsigned DW        = 1 + OPW + AW,
  localparam int unsigned NT        = 1 << SCW,
  localparam int unsigned ND        = 1 << OPW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic          ien_set,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ac_o,
  output logic [DW-1:0] ir_o,
  output logic [NT-1:0] tsig_o,
  output logic [ND-1:0] dsig_o,
  output logic          ien_o
);
  // reset: asserted asynchronously, released on the second clock edge
  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  phase_e         ph_q, ph_d;
  logic [AW-1:0]  pc_q, pc_d, mar_q, mar_d, adr_q, adr_d;
  logic [DW-1:0]  mbr_q, mbr_d, ac_q, ac_d;
  logic [OPW-1:0] op_q, op_d;
  logic           ind_q, ind_d, ien_q, ien_d;

  logic [NT-1:0]  t;
  logic [ND-1:0]  d;
  logic           sc_clr;

  seqctl_seqcnt #(.SCW(SCW)) u_sc (
    .clk(clk), .rst_n(srst_n), .clr(sc_clr), .inc(1'b1), .tsig(t)
  );

  seqctl_opdec #(.OPW(OPW)) u_dec (.op(op_q), .dsig(d));

  // cycle-type qualifiers and opcode classes
  logic c_f, c_i, c_e, c_n, is_add, is_isz, is_mem;
  assign c_f    = (ph_q == PH_FETCH);
  assign c_i    = (ph_q == PH_INDIR);
  assign c_e    = (ph_q == PH_EXEC);
  assign c_n    = (ph_q == PH_INTR);
  assign is_add = d[OP_ADD];
  assign is_isz = d[OP_ISZ];
  assign is_mem = is_add | is_isz;

  // control gates: timing line AND cycle type AND instruction line
  logic ld_mar_pc, ld_mar_ir, ld_mar_sv, ld_mbr_mem, inc_mbr, ld_mbr_pc;
  logic inc_pc, ld_pc_isr, ld_ir, ld_iradr, ld_ac, wr_isz, wr_int;
  logic end_ins, go_intr;

  assign ld_mar_pc  = c_f & t[0];
  assign ld_mar_ir  = (c_i & t[0]) | (c_e & is_mem & t[0]);
  assign ld_mar_sv  = c_n & t[1];
  assign ld_mbr_mem = (c_f | c_i | (c_e & is_mem)) & t[1];
  assign inc_mbr    = c_e & is_isz & t[2];
  assign ld_mbr_pc  = c_n & t[0];
  assign wr_isz     = c_e & is_isz & t[3];
  assign wr_int     = c_n & t[2];
  assign inc_pc     = (c_f & t[1]) | (wr_isz & (mbr_q == '0));
  assign ld_pc_isr  = c_n & t[1];
  assign ld_ir      = c_f & t[2];
  assign ld_iradr   = c_i & t[2];
  assign ld_ac      = c_e & is_add & t[2];
  assign end_ins    = c_e & ((is_add & t[2]) | wr_isz | (~is_mem & t[0]));
  assign go_intr    = end_ins & irq & ien_q;
  assign sc_clr     = ld_ir | ld_iradr | end_ins | wr_int;

  // next-state logic
  always_comb begin
    ph_d  = ph_q;
    pc_d  = pc_q;
    mar_d = mar_q;
    mbr_d = mbr_q;
    ac_d  = ac_q;
    adr_d = adr_q;
    op_d  = op_q;
    ind_d = ind_q;
    ien_d = ien_q;

    if (ld_mar_pc)      mar_d = pc_q;
    else if (ld_mar_ir) mar_d = adr_q;
    else if (ld_mar_sv) mar_d = SAVE_ADDR;

    if (ld_mbr_mem)     mbr_d = mem_rdata;
    else if (inc_mbr)   mbr_d = mbr_q + 1'b1;
    else if (ld_mbr_pc) mbr_d = DW'(pc_q);

    if (ld_pc_isr)      pc_d = ISR_ADDR;
    else if (inc_pc)    pc_d = pc_q + 1'b1;

    if (ld_ir) begin
      ind_d = mbr_q[DW-1];
      op_d  = mbr_q[DW-2 -: OPW];
      adr_d = mbr_q[AW-1:0];
    end else if (ld_iradr) begin
      adr_d = mbr_q[AW-1:0];
    end

    if (ld_ac) ac_d = ac_q + mbr_q;

    if (go_intr)      ien_d = 1'b0;
    else if (ien_set) ien_d = 1'b1;

    if (ld_ir)         ph_d = mbr_q[DW-1] ? PH_INDIR : PH_EXEC;
    else if (ld_iradr) ph_d = PH_EXEC;
    else if (end_ins)  ph_d = go_intr ? PH_INTR : PH_FETCH;
    else if (wr_int)   ph_d = PH_FETCH;
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ph_q  <= PH_FETCH;
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ac_q  <= '0;
      adr_q <= '0;
      op_q  <= '0;
      ind_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      pc_q  <= pc_d;
      mar_q <= mar_d;
      mbr_q <= mbr_d;
      ac_q  <= ac_d;
      adr_q <= adr_d;
      op_q  <= op_d;
      ind_q <= ind_d;
      ien_q <= ien_d;
    end
  end

  assign mem_rd    = ld_mar_pc | ld_mar_ir;
  assign mem_wr    = wr_isz | wr_int;
  assign mem_addr  = ld_mar_pc ? pc_q : (ld_mar_ir ? adr_q : mar_q);
  assign mem_wdata = mbr_q;
  assign pc_o      = pc_q;
  assign ac_o      = ac_q;
  assign ir_o      = {ind_q, op_q, adr_q};
  assign tsig_o    = t;
  assign dsig_o    = d;
  assign ien_o     = ien_q;
endmodule

// File: rtl/seqctl_chk.sv
module seqctl_chk #(
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 16,
  parameter int unsigned NT       = 16,
  parameter logic [11:0] ISR_ADDR = 12'h080
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NT-1:0] tsig,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] ac,
  input logic [7:0]    dsig,
  input logic          ien,
  input logic          mem_rd,
  input logic          mem_wr
);
  // R2: any line other than T0 follows from the line just below it
  p_tstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tsig[0] |-> (tsig == ($past(tsig) << 1)));

  // R10: read and write strobes never overlap
  p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R6: the accumulator changes only while the add line is decoded
  p_ac_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ac != $past(ac)) |-> $past(dsig[1]));

  // R4: the program counter only steps by one or jumps to the routine
  p_pc_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> ((pc == $past(pc) + 1'b1) || (pc == ISR_ADDR)));

  // R9: clearing the enable leads to the routine address two slots later
  p_ien_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ien) |=> ##1 (pc == ISR_ADDR));
endmodule

bind seqctl_top seqctl_chk #(
  .AW(AW), .DW(DW), .NT(NT), .ISR_ADDR(ISR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tsig(tsig_o), .pc(pc_o), .ac(ac_o),
  .dsig(dsig_o), .ien(ien_o), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/sim_seqctl_top.sv
module sim_seqctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  // fields: instr, word at address field, word at pointer target,
  //         cycles, expected AC, expected PC, expected word at effective address
  localparam logic [111:0] VEC [NV] = '{
    {16'h1040, 16'h1234, 16'h0000, 16'd6,  16'h1234, 16'h0001, 16'h1234},
    {16'h1041, 16'hFFFF, 16'h0000, 16'd6,  16'h1233, 16'h0002, 16'hFFFF},
    {16'h9042, 16'hA050, 16'h0011, 16'd9,  16'h1244, 16'h0003, 16'h0011},
    {16'h6043, 16'h0005, 16'h0000, 16'd7,  16'h1244, 16'h0004, 16'h0006},
    {16'h6044, 16'hFFFF, 16'h0000, 16'd7,  16'h1244, 16'h0006, 16'h0000},
    {16'h3045, 16'h7777, 16'h0000, 16'd4,  16'h1244, 16'h0007, 16'h7777},
    {16'hE046, 16'h0060, 16'h7FFF, 16'd10, 16'h1244, 16'h0008, 16'h8000},
    {16'h1047, 16'hEDBC, 16'h0000, 16'd6,  16'h0000, 16'h0009, 16'hEDBC}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic        ien_set = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [11:0] pc_o;
  logic [15:0] ac_o, ir_o, tsig_o;
  logic [7:0]  dsig_o;
  logic        ien_o;

  logic        pl_we = 1'b0;
  logic [7:0]  pl_addr = '0;
  logic [15:0] pl_data = '0;
  logic [15:0] mem [256];
  logic [15:0] rdq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqctl_top u0 (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ien_set(ien_set),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .pc_o(pc_o), .ac_o(ac_o),
    .ir_o(ir_o), .tsig_o(tsig_o), .dsig_o(dsig_o), .ien_o(ien_o)
  );

  // synchronous memory model, one cycle read latency
  always @(posedge clk) begin
    if (pl_we)       mem[pl_addr] <= pl_data;
    else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd)      rdq <= mem[mem_addr[7:0]];
  end
  assign mem_rdata = rdq;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pload(input logic [7:0] a, input logic [15:0] v);
    pl_addr = a;
    pl_data = v;
    pl_we   = 1'b1;
    tick(1);
    pl_we   = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] pcx;
    #1;
    for (int a = 0; a < 256; a++) pload(8'(a), 16'h0000);
    pcx = 16'h0000;
    for (int k = 0; k < NV; k++) begin
      logic [111:0] v;
      v = VEC[k];
      pload(pcx[7:0], v[111:96]);
      pload(v[103:96], v[95:80]);
      if (v[111]) pload(v[87:80], v[79:64]);
      pcx = v[31:16];
    end
    pload(8'h09, 16'h7000);
    pload(8'h0A, 16'h7000);
    pload(8'h0B, 16'h7000);
    pload(8'h80, 16'h7000);

    // R1: reset state, fetch read of address 0 pending
    check("R1 pc", 32'(pc_o), 32'h0);
    check("R1 ac", 32'(ac_o), 32'h0);
    check("R1 tsig", 32'(tsig_o), 32'h0001);
    check("R1 ien", 32'(ien_o), 32'h0);
    check("R1 R10 rd/addr", {mem_rd, mem_wr, 18'h0, mem_addr}, {1'b1, 1'b0, 18'h0, 12'h000});

    rst_n = 1'b1;
    tick(2);
    check("R1 held through sync release", 32'(tsig_o), 32'h0001);

    pcx = 16'h0000;
    for (int k = 0; k < NV; k++) begin
      logic [111:0] v;
      logic [15:0]  ins;
      logic [11:0]  ea;
      string        tg;
      int           rest;
      v    = VEC[k];
      ins  = v[111:96];
      ea   = ins[15] ? v[91:80] : ins[11:0];
      tg   = (ins[14:12] == 3'd6) ? "R7" : ((ins[14:12] == 3'd1) ? "R6" : "R8");
      rest = int'(v[63:48]) - 3 - (ins[15] ? 3 : 0);
      if (k == 0) begin
        tick(1);
        check("R2 T1 after one edge", 32'(tsig_o), 32'h0002);
        tick(2);
      end else begin
        tick(3);
      end
      check("R2 T0 after fetch", 32'(tsig_o), 32'h0001);
      check("R4 ir loaded", 32'(ir_o), 32'(ins));
      check("R4 pc step", 32'(pc_o), 32'(pcx[11:0] + 12'd1));
      check("R3 dline", 32'(dsig_o), 32'(8'd1 << ins[14:12]));
      if (ins[15]) begin
        tick(3);
        check("R5 address replaced", 32'(ir_o), 32'({ins[15:12], ea}));
      end
      tick(rest);
      check({tg, " ac"}, 32'(ac_o), 32'(v[47:32]));
      check({tg, " pc"}, 32'(pc_o), 32'(v[31:16]));
      check({tg, " mem"}, 32'(mem[ea[7:0]]), 32'(v[15:0]));
      pcx = v[31:16];
    end

    // R9: request while the enable is clear is ignored
    irq = 1'b1;
    tick(4);
    check("R9 no entry when disabled", {mem_rd, 19'h0, mem_addr}, {1'b1, 19'h0, 12'h00A});
    tick(4);
    check("R8 pc after no-op", 32'(pc_o), 32'h00B);
    ien_set = 1'b1;
    tick(1);
    ien_set = 1'b0;
    check("R9 enable set", 32'(ien_o), 32'h1);
    tick(3);
    check("R9 entry clears enable", 32'(ien_o), 32'h0);
    check("R9 interrupt slot0 no read", 32'(mem_rd), 32'h0);
    tick(2);
    check("R9 routine address", 32'(pc_o), 32'h080);
    check("R10 save write", {mem_wr, 3'h0, mem_addr, mem_wdata}, {1'b1, 3'h0, 12'h0F0, 16'h000C});
    tick(1);
    check("R9 saved pc in memory", 32'(mem[8'hF0]), 32'h000C);
    check("R2 T0 after interrupt", 32'(tsig_o), 32'h0001);
    tick(4);
    check("R9 no reentry", {mem_rd, 19'h0, mem_addr}, {1'b1, 19'h0, 12'h081});
    irq = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule